// File: doc/BRIEF.md
# Column-Interleaved Sampling Phase Sequencer

This block drives the switches of a sample-and-hold storage matrix with one row per input channel and several capacitor columns. Each column receives a burst of one-cycle sampling strobes, one per channel, in channel order. The strobes are spaced by a programmable number of clock ticks. A new column's burst is launched once every conversion period, and the columns are taken in round-robin order. Bursts of different columns therefore overlap in time.

When a column's last strobe has been issued, that column holds its samples. At the next conversion slot it is the oldest such column, and it is connected to the shared summing stage. The block then raises the charge-transfer strobe, starts the converter and reports which column is being converted. A dump strobe follows to clear the summing stage, and the column returns to the free pool.

The spacing, the conversion period and the number of columns in rotation are latched in a single load cycle. This load cycle happens after reset or after a reconfiguration request. A configuration whose rotation is too short to finish a burst raises an error flag, and the block stays quiet until it is reconfigured.

Top module: `col_phase_seq`

## Requirements
- R1: While reset is held, every strobe, `sumSel`, `adcCol` and `cfgErr` are low or zero.
- R2: A burst launched in cycle s produces exactly NUM_CH one-cycle strobes on the launched column, c, only. Channel k is strobed on bit c*NUM_CH+k of `sampleEn`, in cycle s+1+k*G, where G is the latched `phaseGap`.
- R3: Cycle 0 is the first cycle after the load cycle. Launches happen in cycles j*P, where P is the latched `convPeriod`, for j = 0, 1, 2 and so on. Launch j uses column j mod C, where C is the latched `colCount`.
- R4: Conversion slots fall in the same cycles j*P as the launches. In a slot, the oldest launched column is read if its last strobe was issued at least one cycle before the slot. Reading raises that column's bit of `sumSel`, alone, together with `xferStrobe`, for XFER_LEN cycles from slot+1. This gives an offset D = ceil((8*G+2)/P) between launch and read.
- R5: `adcStart` is high for one cycle, right after the last charge-transfer cycle. `adcCol` holds the index of the column being converted for the whole output phase, and is 0 at all other times.
- R6: `dumpStrobe` is high for one cycle, right after `adcStart`. It is never high in a cycle with `xferStrobe` or in the cycle just after one.
- R7: In the load cycle, the configuration is rejected if any of these holds: `phaseGap` = 0; `colCount` = 0; `colCount` > MAX_COLS; `convPeriod` < XFER_LEN+3; or (NUM_CH-1)*`phaseGap`+2 > (`colCount`-1)*`convPeriod`. On rejection, `cfgErr` goes high from cycle 0 and stays high until the next reconfiguration. No strobe or select rises while it is high.
- R8: Changes to `phaseGap`, `convPeriod` and `colCount` outside the load cycle do not alter the running pattern.
- R9: When `reconfig` is high at a clock edge, all columns are aborted. The next cycle is a load cycle, in which all outputs are low. Operation then restarts from cycle 0 with the newly latched values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all intervals are counted in its ticks |
| rst_n | input | 1 | Asynchronous active-low reset |
| reconfig | input | 1 | Abort and reload the configuration |
| phaseGap | input | CNT_W | Ticks between consecutive channel strobes |
| convPeriod | input | CNT_W | Ticks between conversion slots and between burst launches |
| colCount | input | CI_W+1 | Number of columns in rotation |
| sampleEn | output | MAX_COLS*NUM_CH | Sampling strobes; bit c*NUM_CH+k is channel k of column c |
| sumSel | output | MAX_COLS | Column connected to the summing stage |
| xferStrobe | output | 1 | Charge transfer into the summing stage |
| adcStart | output | 1 | Converter start pulse |
| adcCol | output | CI_W | Index of the column in its output phase |
| dumpStrobe | output | 1 | Clears the summing stage |
| cfgErr | output | 1 | Rejected configuration |

## Verification
The bench builds the block with NUM_CH = 9, MAX_COLS = 8, CNT_W = 10 and XFER_LEN = 2. With these values, counts above the column limit can be driven, and wrap-around of the rotation shows up within a few hundred cycles. A spacing of 1 tick and periods down to the minimum of 5 make bursts overlap across many columns at once. The exact feasibility boundary, where the read offset equals C-1, is exercised directly, next to rejected neighbours on each side of every error term.

// File: rtl/col_seq_pkg.sv
`timescale 1ns/1ps
package col_seq_pkg;
  typedef enum logic [1:0] {COL_IDLE, COL_SAMPLE, COL_HOLD, COL_OUT} colState_t;
  typedef enum logic [1:0] {ST_LOAD, ST_RUN, ST_HALT} seqState_t;
  typedef struct packed {
    logic launch;
    logic read;
    logic clear;
  } seqStrobe_t;
endpackage

// File: rtl/col_seq_ctrl.sv
`timescale 1ns/1ps
module col_seq_ctrl
  import col_seq_pkg::*;
#(
  parameter int NUM_CH   = 9,
  parameter int MAX_COLS = 41,
  parameter int CNT_W    = 16,
  parameter int XFER_LEN = 2,
  localparam int CI_W    = $clog2(MAX_COLS),
  localparam int COL_W   = CI_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reconfig,
  input  logic [CNT_W-1:0]    phaseGap,
  input  logic [CNT_W-1:0]    convPeriod,
  input  logic [COL_W-1:0]    colCount,
  input  logic [MAX_COLS-1:0] colDone,
  output seqStrobe_t          strobes,
  output logic [CI_W-1:0]     launchIdx,
  output logic [CI_W-1:0]     readIdx,
  output logic [CNT_W-1:0]    gapCfg,
  output logic                cfgErr
);
  localparam int CW = CNT_W + COL_W + 4;

  seqState_t        state;
  logic [CNT_W-1:0] perCfg;
  logic [CNT_W-1:0] slotCnt;
  logic [COL_W-1:0] colsCfg;
  logic             cfgOk;
  logic             slotTick;
  logic [CW-1:0]    burstSpan;
  logic [CW-1:0]    rotSpan;

  // feasibility: last strobe plus hold detection must fit before reuse
  always_comb begin
    burstSpan = CW'(phaseGap) * CW'(NUM_CH - 1) + CW'(2);
    rotSpan   = (CW'(colCount) - CW'(1)) * CW'(convPeriod);
    cfgOk     = (phaseGap != '0) && (colCount != '0) &&
                (colCount <= COL_W'(MAX_COLS)) &&
                (convPeriod >= CNT_W'(XFER_LEN + 3)) &&
                (burstSpan <= rotSpan);
  end

  assign slotTick       = (state == ST_RUN) && (slotCnt == '0) && !reconfig;
  assign strobes.launch = slotTick;
  assign strobes.read   = slotTick && colDone[readIdx];
  assign strobes.clear  = reconfig;
  assign cfgErr         = (state == ST_HALT);

  function automatic logic [CI_W-1:0] nextIdx(input logic [CI_W-1:0] idx,
                                               input logic [COL_W-1:0] lim);
    return ((COL_W'(idx) + COL_W'(1)) >= lim) ? '0 : idx + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_LOAD;
      gapCfg    <= '0;
      perCfg    <= '0;
      colsCfg   <= '0;
      slotCnt   <= '0;
      launchIdx <= '0;
      readIdx   <= '0;
    end else if (reconfig) begin
      state     <= ST_LOAD;
      slotCnt   <= '0;
      launchIdx <= '0;
      readIdx   <= '0;
    end else begin
      case (state)
        ST_LOAD: begin
          gapCfg    <= phaseGap;
          perCfg    <= convPeriod;
          colsCfg   <= colCount;
          state     <= cfgOk ? ST_RUN : ST_HALT;
          slotCnt   <= '0;
          launchIdx <= '0;
          readIdx   <= '0;
        end
        ST_RUN: begin
          slotCnt <= (slotCnt == perCfg - 1'b1) ? '0 : slotCnt + 1'b1;
          if (slotTick)     launchIdx <= nextIdx(launchIdx, colsCfg);
          if (strobes.read) readIdx   <= nextIdx(readIdx, colsCfg);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/col_seq_columns.sv
`timescale 1ns/1ps
module col_seq_columns
  import col_seq_pkg::*;
#(
  parameter int NUM_CH   = 9,
  parameter int MAX_COLS = 41,
  parameter int CNT_W    = 16,
  parameter int XFER_LEN = 2,
  localparam int CI_W    = $clog2(MAX_COLS),
  localparam int PH_W    = $clog2(NUM_CH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  seqStrobe_t                 strobes,
  input  logic [CI_W-1:0]            launchIdx,
  input  logic [CI_W-1:0]            readIdx,
  input  logic [CNT_W-1:0]           gapCfg,
  output logic [MAX_COLS*NUM_CH-1:0] sampleEn,
  output logic [MAX_COLS-1:0]        colDone,
  output logic [MAX_COLS-1:0]        sumSel,
  output logic                       xferStrobe,
  output logic                       adcStart,
  output logic                       dumpStrobe,
  output logic [CI_W-1:0]            adcCol
);
  localparam logic [NUM_CH-1:0] TAP0 = {{(NUM_CH-1){1'b0}}, 1'b1};

  logic [MAX_COLS-1:0] outMask;
  logic [MAX_COLS-1:0] adcMask;
  logic [MAX_COLS-1:0] dumpMask;

  for (genvar c = 0; c < MAX_COLS; c++) begin : g_col
    colState_t        colSt;
    logic [PH_W-1:0]  phase;
    logic [CNT_W-1:0] tick;

    // the phase counter acts as the tapped delay chain, one tap per gap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        colSt <= COL_IDLE;
        phase <= '0;
        tick  <= '0;
      end else if (strobes.clear) begin
        colSt <= COL_IDLE;
        phase <= '0;
        tick  <= '0;
      end else begin
        case (colSt)
          COL_IDLE:
            if (strobes.launch && launchIdx == CI_W'(c)) begin
              colSt <= COL_SAMPLE;
              phase <= '0;
              tick  <= '0;
            end
          COL_SAMPLE:
            if (tick == '0 && phase == PH_W'(NUM_CH - 1)) begin
              colSt <= COL_HOLD;
            end else if (tick == gapCfg - 1'b1) begin
              tick  <= '0;
              phase <= phase + 1'b1;
            end else begin
              tick <= tick + 1'b1;
            end
          COL_HOLD:
            if (strobes.read && readIdx == CI_W'(c)) begin
              colSt <= COL_OUT;
              tick  <= '0;
            end
          default:
            if (tick == CNT_W'(XFER_LEN + 1)) colSt <= COL_IDLE;
            else                              tick  <= tick + 1'b1;
        endcase
      end
    end

    assign sampleEn[c*NUM_CH +: NUM_CH] =
      (colSt == COL_SAMPLE && tick == '0) ? (TAP0 << phase) : '0;
    assign colDone[c]  = (colSt == COL_HOLD);
    assign outMask[c]  = (colSt == COL_OUT);
    assign sumSel[c]   = outMask[c] && (tick < CNT_W'(XFER_LEN));
    assign adcMask[c]  = outMask[c] && (tick == CNT_W'(XFER_LEN));
    assign dumpMask[c] = outMask[c] && (tick == CNT_W'(XFER_LEN + 1));
  end

  assign xferStrobe = |sumSel;
  assign adcStart   = |adcMask;
  assign dumpStrobe = |dumpMask;

  always_comb begin
    adcCol = '0;
    for (int c = 0; c < MAX_COLS; c++) begin
      if (outMask[c]) adcCol = adcCol | CI_W'(c);
    end
  end
endmodule

// File: rtl/col_phase_seq.sv
`timescale 1ns/1ps
module col_phase_seq
  import col_seq_pkg::*;
#(
  parameter int NUM_CH   = 9,
  parameter int MAX_COLS = 41,
  parameter int CNT_W    = 16,
  parameter int XFER_LEN = 2,
  localparam int CI_W    = $clog2(MAX_COLS),
  localparam int COL_W   = CI_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reconfig,
  input  logic [CNT_W-1:0]           phaseGap,
  input  logic [CNT_W-1:0]           convPeriod,
  input  logic [COL_W-1:0]           colCount,
  output logic [MAX_COLS*NUM_CH-1:0] sampleEn,
  output logic [MAX_COLS-1:0]        sumSel,
  output logic                       xferStrobe,
  output logic                       adcStart,
  output logic [CI_W-1:0]            adcCol,
  output logic                       dumpStrobe,
  output logic                       cfgErr
);
  seqStrobe_t          strobes;
  logic [CI_W-1:0]     launchIdx;
  logic [CI_W-1:0]     readIdx;
  logic [CNT_W-1:0]    gapCfg;
  logic [MAX_COLS-1:0] colDone;

  col_seq_ctrl #(
    .NUM_CH(NUM_CH), .MAX_COLS(MAX_COLS), .CNT_W(CNT_W), .XFER_LEN(XFER_LEN)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reconfig(reconfig),
    .phaseGap(phaseGap), .convPeriod(convPeriod), .colCount(colCount),
    .colDone(colDone), .strobes(strobes), .launchIdx(launchIdx),
    .readIdx(readIdx), .gapCfg(gapCfg), .cfgErr(cfgErr)
  );

  col_seq_columns #(
    .NUM_CH(NUM_CH), .MAX_COLS(MAX_COLS), .CNT_W(CNT_W), .XFER_LEN(XFER_LEN)
  ) u_cols (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .launchIdx(launchIdx),
    .readIdx(readIdx), .gapCfg(gapCfg), .sampleEn(sampleEn),
    .colDone(colDone), .sumSel(sumSel), .xferStrobe(xferStrobe),
    .adcStart(adcStart), .dumpStrobe(dumpStrobe), .adcCol(adcCol)
  );
endmodule

// File: rtl/col_phase_seq_checks.sv
`timescale 1ns/1ps
module col_phase_seq_checks #(
  parameter int NUM_CH   = 9,
  parameter int MAX_COLS = 41
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [MAX_COLS*NUM_CH-1:0] sampleEn,
  input logic [MAX_COLS-1:0]        sumSel,
  input logic                       xferStrobe,
  input logic                       adcStart,
  input logic                       dumpStrobe,
  input logic                       cfgErr
);
  for (genvar c = 0; c < MAX_COLS; c++) begin : g_chk
    a_r2_one_strobe_per_col: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sampleEn[c*NUM_CH +: NUM_CH]));
  end

  a_r4_sum_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sumSel));

  a_r4_xfer_with_select: assert property (@(posedge clk) disable iff (!rst_n)
    xferStrobe |-> (sumSel != '0));

  a_r5_adc_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    adcStart |-> ($past(xferStrobe) && !xferStrobe));

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(dumpStrobe && xferStrobe));

  a_r6_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    xferStrobe |=> !dumpStrobe);

  a_r7_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfgErr |-> (sampleEn == '0 && sumSel == '0 && !adcStart && !dumpStrobe));
endmodule

bind col_phase_seq col_phase_seq_checks #(
  .NUM_CH(NUM_CH), .MAX_COLS(MAX_COLS)
) u_checks (
  .clk(clk), .rst_n(rst_n), .sampleEn(sampleEn), .sumSel(sumSel),
  .xferStrobe(xferStrobe), .adcStart(adcStart), .dumpStrobe(dumpStrobe),
  .cfgErr(cfgErr)
);

// File: tb/col_phase_seq_bench.sv
`timescale 1ns/1ps
module col_phase_seq_bench;
  localparam int NCH = 9;
  localparam int NCOL = 8;
  localparam int CW = 10;
  localparam int XL = 2;
  localparam int CIW = $clog2(NCOL);

  logic clk = 1'b0;
  logic rst_n, reconfig;
  logic [CW-1:0] phaseGap, convPeriod;
  logic [CIW:0] colCount;
  logic [NCOL*NCH-1:0] sampleEn;
  logic [NCOL-1:0] sumSel;
  logic xferStrobe, adcStart, dumpStrobe, cfgErr;
  logic [CIW-1:0] adcCol;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int mGap, mPer, mCols, mD;
  bit mErr;

  always #4 clk = ~clk;

  col_phase_seq #(.NUM_CH(NCH), .MAX_COLS(NCOL), .CNT_W(CW), .XFER_LEN(XL)) u_col_phase_seq (
    .clk(clk), .rst_n(rst_n), .reconfig(reconfig), .phaseGap(phaseGap),
    .convPeriod(convPeriod), .colCount(colCount), .sampleEn(sampleEn),
    .sumSel(sumSel), .xferStrobe(xferStrobe), .adcStart(adcStart),
    .adcCol(adcCol), .dumpStrobe(dumpStrobe), .cfgErr(cfgErr));

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit cfgBad(int g, int p, int c);
    return g == 0 || c == 0 || c > NCOL || p < XL + 3 || (NCH - 1) * g + 2 > (c - 1) * p;
  endfunction

  task automatic setModel(int g, int p, int c);
    mGap = g; mPer = p; mCols = c;
    mErr = cfgBad(g, p, c);
    mD = mErr ? 0 : ((NCH - 1) * g + 2 + p - 1) / p;
  endtask

  function automatic bit sampleHit(int n, int c, int k);
    int m;
    m = n - 1 - k * mGap;
    if (m < 0 || (m % mPer) != 0) return 0;
    return ((m / mPer) % mCols) == c;
  endfunction

  task automatic checkCycle(int n, string label);
    logic [127:0] expSE = '0;
    logic [NCOL-1:0] expSum = '0;
    int o, j, col;
    bit act;
    if (!mErr)
      for (int c = 0; c < NCOL; c++)
        for (int k = 0; k < NCH; k++)
          if (sampleHit(n, c, k)) expSE[c*NCH+k] = 1'b1;
    act = 0; col = 0; o = 0;
    if (!mErr) begin
      o = n % mPer; j = n / mPer;
      act = (o >= 1) && (o <= XL + 2) && (j >= mD);
      if (act) col = (j - mD) % mCols;
    end
    if (act && o <= XL) expSum[col] = 1'b1;
    check(sampleEn == expSE[NCOL*NCH-1:0], {label, " R2 R3 strobes"}, 128'(sampleEn), expSE);
    check({xferStrobe, sumSel} == {act && o <= XL, expSum}, {label, " R4 transfer"},
          128'({xferStrobe, sumSel}), 128'({act && o <= XL, expSum}));
    check({adcStart, adcCol} == {act && o == XL + 1, CIW'(col)}, {label, " R5 adc"},
          128'({adcStart, adcCol}), 128'({act && o == XL + 1, CIW'(col)}));
    check(dumpStrobe == (act && o == XL + 2), {label, " R6 dump"},
          128'(dumpStrobe), 128'(act && o == XL + 2));
    check(cfgErr == mErr, {label, " R7 error flag"}, 128'(cfgErr), 128'(mErr));
  endtask

  task automatic loopCheck(int nCyc, string label, int changeAt);
    for (int n = 0; n < nCyc; n++) begin
      @(negedge clk);
      checkCycle(n, label);
      if (n == changeAt) begin
        phaseGap   = CW'(mGap + 1);
        convPeriod = CW'(mPer + 3);
        colCount   = (CIW+1)'(mCols - 1);
      end
    end
  endtask

  task automatic runCfg(int g, int p, int c, string label, int changeAt);
    int nCyc;
    phaseGap = CW'(g); convPeriod = CW'(p); colCount = (CIW+1)'(c);
    reconfig = 1'b1;
    @(negedge clk);
    reconfig = 1'b0;
    check(sampleEn == '0 && sumSel == '0 && !xferStrobe && !adcStart && !dumpStrobe && !cfgErr,
          {label, " R9 load cycle quiet"}, 128'({sampleEn, cfgErr}), 128'(0));
    setModel(g, p, c);
    nCyc = mErr ? 40 : p * (c + mD + 2) + 10;
    loopCheck(nCyc, label, changeAt);
  endtask

  initial begin
    int g, p, c;
    void'($urandom(32'd4242));
    rst_n = 1'b0; reconfig = 1'b0;
    phaseGap = 3; convPeriod = 10; colCount = 4;
    repeat (3) @(negedge clk);
    check(sampleEn == '0 && sumSel == '0 && !xferStrobe && !adcStart && !dumpStrobe &&
          adcCol == '0 && !cfgErr, "R1 reset state", 128'({sampleEn, cfgErr}), 128'(0));
    rst_n = 1'b1;
    setModel(3, 10, 4);
    loopCheck(200, "base", -1);
    runCfg(1, 5, 8, "dense overlap", -1);
    runCfg(2, 6, 4, "R7 exact boundary accepted", -1);
    runCfg(2, 5, 4, "R7 span too long", -1);
    runCfg(0, 10, 4, "R7 zero gap", -1);
    runCfg(3, 10, 0, "R7 zero columns", -1);
    runCfg(1, 10, 9, "R7 too many columns", -1);
    runCfg(1, 4, 8, "R7 short period", -1);
    runCfg(3, 10, 4, "R8 inputs change mid-run", 40);
    runCfg(5, 7, 8, "R9 restart after change", -1);
    for (int t = 0; t < 16; t++) begin
      g = $urandom_range(8, 1);
      p = $urandom_range(24, 5);
      c = $urandom_range(9, 1);
      runCfg(g, p, c, "random", -1);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule